// File: doc/BRIEF.md
# Multi-Source Match Channel Bank

This block holds eight match channels, numbered 4 through 11. Each channel has a 32-bit up-counter, a match value and a control word. The counter advances on cycles when a chosen tick-enable input is high. Five tick-enable inputs are available: 32.768 kHz, 1 kHz, 1 Hz, 1 MHz and an external rate. The prescalers that make these enables sit outside the block. A channel can instead compare its match value against the counter of a lead channel. When the compared count steps onto the match value, the channel's status bit is set, provided its enable bit is set. One shared interrupt line reports whether any of the eight status bits is set.

Software reaches the block through a simple word-addressed register port. Reads are combinational. Writes take effect at the clock edge. The upper channels have one more option: reading the counter of channel 9 or 11 can latch the live count of its lead channel (8 or 10) into a snapshot register in the same cycle. This gives a coherent pair of values.

Top module: `mchan_bank`

## Requirements
- R1: After reset, every counter, match value, control word, enable bit and status bit reads 0, the snapshot reads 0 and `irq` is low.
- R2: Control bits [2:0] pick the rate. Code k (1..5) advances the counter once per clock in which `tickIn[k-1]` is high. Codes 0, 6 and 7 hold the counter.
- R3: Register map, byte offsets: counter of channel 4+i at 0x40+4i, match at 0x80+4i, control at 0xC0+4i (i = 0..7), snapshot at 0x20, status at 0x14, enable at 0x1C. In status and enable, bit n (4..11) belongs to channel n. A counter write loads the value and takes priority over a tick in the same cycle.
- R4: When the compared counter increments to equal the match value, status bit n is set on that same edge, but only if enable bit n is 1.
- R5: With control bit 3 set, a channel's own counter goes to 0 on its match instead of holding the match value.
- R6: With control bit 6 clear, a channel matches once and then stays quiet until its match value or control word is written again. With bit 6 set, every later match also fires.
- R7: With control bit 7 clear, channels 5–7 compare against channel 4's counter, channel 9 against channel 8's, and channel 11 against channel 10's. In that mode their own counter does not advance. Channels 4, 8 and 10 always run on their own counter.
- R8: Controls of channels 4–7 keep bits [7:0] only. Controls of channels 8–11 keep bits [9:0]. On channels 8–11, bit 8 set holds the counter whatever the rate code.
- R9: A read of channel 9's counter while its control bit 9 is set copies channel 8's current count into the snapshot. The same holds for channel 11 with channel 10. A read with bit 9 clear leaves the snapshot unchanged.
- R10: Writing 1 to status bits 4..11 clears them, and bits outside 4..11 are ignored. Matches in the same cycle set all their status bits together. `irq` is high exactly one cycle after any status bit is set, and it drops one cycle after the last one clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickIn | input | 5 | Tick enables: 32.768 kHz, 1 kHz, 1 Hz, 1 MHz, external |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (arms the snapshot side effect) |
| regAddr | input | 8 | Byte offset of the register |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr` |
| irq | output | 1 | Combined match interrupt |

## Verification
The assertions assume that a read and a write never target the same register in the same cycle. They also assume that `regAddr` is word-aligned whenever a strobe is high. The bench issues one access per idle cycle and always uses aligned offsets. The assertions further assume that a counter only changes by increment, clear or write. The stimulus drives ticks only through `tickIn`, at negative edges, with the register strobes low, so each count change can be tied to one cause. Match values are placed far above the counts reached in the rate sweep, so no stray matches occur there.

// File: rtl/mchan_pkg.sv
package mchan_pkg;
  localparam int NCH     = 8;
  localparam int CH_BASE = 4;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 8;
  localparam int CTRL_W  = 10;
  localparam int IDX_W   = $clog2(NCH);

  localparam int B_CLR   = 3;
  localparam int B_REARM = 6;
  localparam int B_OWN   = 7;
  localparam int B_HALT  = 8;
  localparam int B_SNAP  = 9;

  localparam logic [ADDR_W-1:0] A_SNAP   = 8'h20;
  localparam logic [ADDR_W-1:0] A_STATUS = 8'h14;
  localparam logic [ADDR_W-1:0] A_ENABLE = 8'h1C;

  typedef enum logic [2:0] {
    RD_NONE, RD_MATCH, RD_COUNT, RD_CTRL, RD_SNAP, RD_STATUS, RD_ENABLE
  } rd_kind_e;

  typedef struct packed {
    logic [NCH-1:0] wrMatch;
    logic [NCH-1:0] wrCount;
    logic [NCH-1:0] wrCtrl;
    logic           wrStatus;
    logic           wrEnable;
    logic           snapTake;
    logic           snapHi;
    rd_kind_e       rdKind;
    logic [IDX_W-1:0] rdIdx;
  } ctl_strobe_t;
endpackage

// File: rtl/mchan_ctrl.sv
module mchan_ctrl
  import mchan_pkg::*;
(
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [1:0]        snapArm,
  output ctl_strobe_t       strobe
);
  logic [IDX_W-1:0] idx;
  logic             aligned;

  assign idx     = regAddr[IDX_W+1:2];
  assign aligned = (regAddr[1:0] == 2'b00);

  always_comb begin
    strobe        = '0;
    strobe.rdKind = RD_NONE;
    strobe.rdIdx  = idx;
    if (aligned) begin
      unique case (regAddr[7:5])
        3'b010: begin
          strobe.rdKind       = RD_COUNT;
          strobe.wrCount[idx] = regWrEn;
          if (regRdEn && idx == IDX_W'(5) && snapArm[0]) begin
            strobe.snapTake = 1'b1;
            strobe.snapHi   = 1'b0;
          end
          if (regRdEn && idx == IDX_W'(7) && snapArm[1]) begin
            strobe.snapTake = 1'b1;
            strobe.snapHi   = 1'b1;
          end
        end
        3'b100: begin
          strobe.rdKind       = RD_MATCH;
          strobe.wrMatch[idx] = regWrEn;
        end
        3'b110: begin
          strobe.rdKind      = RD_CTRL;
          strobe.wrCtrl[idx] = regWrEn;
        end
        default: begin
          if (regAddr == A_SNAP) begin
            strobe.rdKind = RD_SNAP;
          end else if (regAddr == A_STATUS) begin
            strobe.rdKind   = RD_STATUS;
            strobe.wrStatus = regWrEn;
          end else if (regAddr == A_ENABLE) begin
            strobe.rdKind   = RD_ENABLE;
            strobe.wrEnable = regWrEn;
          end
        end
      endcase
    end
  end

  // R3: a write reaches at most one register
  always_comb begin
    a_r3_one_target: assert ($onehot0({strobe.wrMatch, strobe.wrCount, strobe.wrCtrl,
                                       strobe.wrStatus, strobe.wrEnable}));
    // R9: the snapshot is only taken by a read
    a_r9_take_needs_read: assert (!strobe.snapTake || regRdEn);
  end
endmodule

// File: rtl/mchan_datapath.sv
module mchan_datapath
  import mchan_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int NUM_TICK = 5
)(
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_TICK-1:0] tickIn,
  input  ctl_strobe_t         strobe,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  output logic [1:0]          snapArm,
  output logic                irq
);
  localparam int HALF = NCH / 2;

  logic [CNT_W-1:0]  cntQ   [NCH];
  logic [CNT_W-1:0]  matchQ [NCH];
  logic [CNT_W-1:0]  incVal [NCH];
  logic [CTRL_W-1:0] ctrlQ  [NCH];
  logic [NCH-1:0]    armedQ, statusQ, enableQ;
  logic [NCH-1:0]    ownMode, stepOn, hitNow, matchEv;
  logic [CNT_W-1:0]  snapQ;
  logic              irqQ;

  function automatic logic tickOf(input logic [2:0] code, input logic [NUM_TICK-1:0] t);
    logic r;
    r = 1'b0;
    for (int k = 0; k < NUM_TICK; k++)
      if (code == 3'(k + 1)) r = t[k];
    return r;
  endfunction

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam bit IS_UPPER  = (g >= HALF);
    localparam bit IS_LEADER = (g == 0) || (g == 4) || (g == 6);
    localparam int LEADER    = (g < 4) ? 0 : ((g < 6) ? 4 : 6);

    logic halted;
    assign halted     = IS_UPPER && ctrlQ[g][B_HALT];
    assign ownMode[g] = ctrlQ[g][B_OWN] || IS_LEADER;
    assign stepOn[g]  = ownMode[g] && !halted && tickOf(ctrlQ[g][2:0], tickIn);
    assign incVal[g]  = cntQ[g] + 1'b1;
    assign hitNow[g]  = ownMode[g] ? (stepOn[g] && incVal[g] == matchQ[g])
                                   : (stepOn[LEADER] && incVal[LEADER] == matchQ[g]);
    assign matchEv[g] = hitNow[g] && armedQ[g];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cntQ[g]    <= '0;
        matchQ[g]  <= '0;
        ctrlQ[g]   <= '0;
        armedQ[g]  <= 1'b0;
        statusQ[g] <= 1'b0;
      end else begin
        if (strobe.wrCount[g])                     cntQ[g] <= CNT_W'(wrData);
        else if (matchEv[g] && ctrlQ[g][B_CLR])    cntQ[g] <= '0;
        else if (stepOn[g])                        cntQ[g] <= incVal[g];

        if (strobe.wrMatch[g]) matchQ[g] <= CNT_W'(wrData);

        if (strobe.wrCtrl[g])
          ctrlQ[g] <= IS_UPPER ? wrData[CTRL_W-1:0] : {2'b00, wrData[7:0]};

        if (strobe.wrMatch[g] || strobe.wrCtrl[g])      armedQ[g] <= 1'b1;
        else if (matchEv[g] && !ctrlQ[g][B_REARM])      armedQ[g] <= 1'b0;

        if (matchEv[g] && enableQ[g])                   statusQ[g] <= 1'b1;
        else if (strobe.wrStatus && wrData[CH_BASE+g])  statusQ[g] <= 1'b0;
      end
    end

    // R2: a counter only steps by one, clears or is loaded
    a_r2_step_one: assert property (@(posedge clk) disable iff (!rstN)
      !$stable(cntQ[g]) |-> (cntQ[g] == $past(cntQ[g]) + 1'b1) || (cntQ[g] == '0)
                            || $past(strobe.wrCount[g]));
    // R4: a status bit can only rise while enabled
    a_r4_enable_gate: assert property (@(posedge clk) disable iff (!rstN)
      $rose(statusQ[g]) |-> $past(enableQ[g]));
    // R6: disarming only happens in one-shot mode
    a_r6_oneshot_disarm: assert property (@(posedge clk) disable iff (!rstN)
      $fell(armedQ[g]) |-> !$past(ctrlQ[g][B_REARM]));
    // R10: status bits are cleared only by a status write
    a_r10_clear_by_write: assert property (@(posedge clk) disable iff (!rstN)
      $fell(statusQ[g]) |-> $past(strobe.wrStatus));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ <= '0;
      snapQ   <= '0;
      irqQ    <= 1'b0;
    end else begin
      if (strobe.wrEnable) enableQ <= wrData[CH_BASE +: NCH];
      if (strobe.snapTake) snapQ   <= strobe.snapHi ? cntQ[6] : cntQ[4];
      irqQ <= |statusQ;
    end
  end

  // R9: the snapshot only moves after an armed read
  a_r9_snap_on_read: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(snapQ) |-> $past(strobe.snapTake));
  // R10: a rising interrupt follows a set status bit
  a_r10_irq_after_status: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqQ) |-> $past(statusQ) != '0);

  assign snapArm = {ctrlQ[7][B_SNAP], ctrlQ[5][B_SNAP]};
  assign irq     = irqQ;

  always_comb begin
    unique case (strobe.rdKind)
      RD_MATCH:  rdData = DATA_W'(matchQ[strobe.rdIdx]);
      RD_COUNT:  rdData = DATA_W'(cntQ[strobe.rdIdx]);
      RD_CTRL:   rdData = DATA_W'(ctrlQ[strobe.rdIdx]);
      RD_SNAP:   rdData = DATA_W'(snapQ);
      RD_STATUS: rdData = DATA_W'({statusQ, {CH_BASE{1'b0}}});
      RD_ENABLE: rdData = DATA_W'({enableQ, {CH_BASE{1'b0}}});
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/mchan_bank.sv
module mchan_bank
  import mchan_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int NUM_TICK = 5
)(
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_TICK-1:0] tickIn,
  input  logic                regWrEn,
  input  logic                regRdEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWrData,
  output logic [DATA_W-1:0]   regRdData,
  output logic                irq
);
  ctl_strobe_t strobe;
  logic [1:0]  snapArm;

  mchan_ctrl u_ctrl (
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .regAddr (regAddr),
    .snapArm (snapArm),
    .strobe  (strobe)
  );

  mchan_datapath #(.CNT_W(CNT_W), .NUM_TICK(NUM_TICK)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .tickIn  (tickIn),
    .strobe  (strobe),
    .wrData  (regWrData),
    .rdData  (regRdData),
    .snapArm (snapArm),
    .irq     (irq)
  );
endmodule

// File: tb/mchan_bank_tb.sv
module mchan_bank_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  tickIn = '0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irq;
  int nChecks = 0, nFail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mchan_bank u_dut (.clk(clk), .rstN(rstN), .tickIn(tickIn), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irq(irq));

  function automatic logic [7:0] aCnt(int i);   return 8'(8'h40 + 4*i); endfunction
  function automatic logic [7:0] aMatch(int i); return 8'(8'h80 + 4*i); endfunction
  function automatic logic [7:0] aCtrl(int i);  return 8'(8'hC0 + 4*i); endfunction
  localparam logic [7:0] A_SN = 8'h20, A_ST = 8'h14, A_EN = 8'h1C;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); regRdEn = 1'b1; regAddr = a; #1 d = regRdData;
    @(negedge clk); regRdEn = 1'b0;
  endtask

  task automatic expRd(input string req, input logic [7:0] a, input logic [31:0] e);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, e);
  endtask

  task automatic tick(input logic [4:0] m, input int n);
    repeat (n) begin @(negedge clk); tickIn = m; end
    @(negedge clk); tickIn = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog (all requirements): got hang expected finish");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    chk("R1 irq", 32'(irq), 0);
    for (int i = 0; i < 8; i++) begin
      expRd("R1 cnt", aCnt(i), 0);
      expRd("R1 match", aMatch(i), 0);
      expRd("R1 ctrl", aCtrl(i), 0);
    end
    expRd("R1 snap", A_SN, 0);
    expRd("R1 status", A_ST, 0);
    expRd("R1 enable", A_EN, 0);

    // R3 / R8: map, control widths
    for (int i = 0; i < 8; i++) begin
      wr(aCtrl(i), 32'hFFFF_FF77);
      expRd("R8 ctrl width", aCtrl(i), (i < 4) ? 32'h77 : 32'h377);
      wr(aMatch(i), 32'hA500_0000 | 32'(i * 32'h111));
      expRd("R3 match", aMatch(i), 32'hA500_0000 | 32'(i * 32'h111));
      wr(aCnt(i), 32'h0C00_0000 + 32'(i));
      expRd("R3 cnt", aCnt(i), 32'h0C00_0000 + 32'(i));
    end
    wr(A_EN, 32'hFFFF_FFFF);
    expRd("R3 enable", A_EN, 32'h0000_0FF0);
    wr(A_EN, 0);

    // R2: sweep every channel and rate code
    for (int ch = 0; ch < 8; ch++) begin
      for (int code = 0; code < 8; code++) begin
        int expCnt;
        expCnt = 0;
        wr(aCtrl(ch), 32'h80 | 32'(code));
        wr(aCnt(ch), 0);
        for (int j = 0; j < 20; j++) begin
          logic [4:0] p;
          p = 5'((j * 13 + code * 7 + ch * 3) % 32);
          @(negedge clk); tickIn = p;
          if (code >= 1 && code <= 5 && p[code-1]) expCnt++;
        end
        @(negedge clk); tickIn = '0;
        expRd("R2 rate", aCnt(ch), 32'(expCnt));
      end
    end

    // R3: count write beats tick
    wr(aCtrl(0), 32'h81);
    @(negedge clk); tickIn = 5'b1; regWrEn = 1'b1; regAddr = aCnt(0); regWrData = 32'h50;
    @(negedge clk); tickIn = '0; regWrEn = 1'b0;
    expRd("R3 write priority", aCnt(0), 32'h50);

    // R4: match sets status
    wr(A_EN, 32'hFF0);
    wr(aMatch(0), 5); wr(aCtrl(0), 32'h81); wr(aCnt(0), 0);
    tick(5'b1, 4);
    expRd("R4 no early", A_ST, 0);
    expRd("R4 cnt", aCnt(0), 4);
    tick(5'b1, 1);
    expRd("R4 status", A_ST, 32'h10);
    expRd("R4 hold", aCnt(0), 5);
    chk("R10 irq high", 32'(irq), 1);
    wr(A_ST, 32'h10);
    expRd("R10 cleared", A_ST, 0);
    chk("R10 irq low", 32'(irq), 0);

    // R5 / R6: clear-on-match, one-shot
    wr(aCtrl(0), 32'h89); wr(aCnt(0), 0);
    tick(5'b1, 5);
    expRd("R6 first", A_ST, 32'h10);
    expRd("R5 cleared", aCnt(0), 0);
    wr(A_ST, 32'h10);
    tick(5'b1, 5);
    expRd("R6 quiet", A_ST, 0);
    expRd("R6 no clear", aCnt(0), 5);
    wr(aMatch(0), 7);
    tick(5'b1, 2);
    expRd("R6 rearm by match write", A_ST, 32'h10);
    expRd("R5 cleared again", aCnt(0), 0);
    // periodic
    wr(A_ST, 32'h10); wr(aMatch(0), 5); wr(aCtrl(0), 32'hC9); wr(aCnt(0), 0);
    tick(5'b1, 10);
    expRd("R5 periodic cnt", aCnt(0), 0);
    expRd("R6 periodic status", A_ST, 32'h10);
    wr(A_ST, 32'h10);
    tick(5'b1, 5);
    expRd("R6 periodic again", A_ST, 32'h10);
    // disabled
    wr(A_EN, 32'hFE0); wr(A_ST, 32'hFF0);
    tick(5'b1, 5);
    expRd("R4 disabled", A_ST, 0);
    expRd("R4 disabled cnt", aCnt(0), 0);
    wr(A_EN, 32'hFF0);

    // R7: followers
    wr(aCtrl(0), 32'h81); wr(aMatch(0), 32'hFFFF); wr(aCnt(0), 0);
    wr(aMatch(1), 3); wr(aCnt(1), 32'h100); wr(aCtrl(1), 32'h01);
    wr(A_ST, 32'hFF0);
    tick(5'b1, 3);
    expRd("R7 follow 5->4", A_ST, 32'h20);
    expRd("R7 own held", aCnt(1), 32'h100);
    expRd("R7 leader cnt", aCnt(0), 3);
    wr(aCtrl(6), 32'h82); wr(aCnt(6), 0); wr(aMatch(6), 32'hFFFF);
    wr(aMatch(7), 2); wr(aCnt(7), 32'h55); wr(aCtrl(7), 32'h000);
    wr(A_ST, 32'hFF0);
    tick(5'b00010, 2);
    expRd("R7 follow 11->10", A_ST, 32'h800);
    expRd("R7 own held 11", aCnt(7), 32'h55);

    // R8: halt bit on upper, dropped on lower
    wr(aCtrl(4), 32'h181); wr(aCnt(4), 0);
    tick(5'b1, 3);
    expRd("R8 halt", aCnt(4), 0);
    wr(aCtrl(0), 32'h181);
    expRd("R8 lower drops bit8", aCtrl(0), 32'h81);
    wr(aCnt(0), 0);
    tick(5'b1, 3);
    expRd("R8 lower counts", aCnt(0), 3);

    // R9: snapshot
    wr(aCnt(4), 32'h1234);
    wr(aCtrl(5), 32'h280);
    expRd("R9 ctrl bit9 kept", aCtrl(5), 32'h280);
    rd(aCnt(5), d);
    expRd("R9 snap 8", A_SN, 32'h1234);
    wr(aCnt(4), 32'h9999); wr(aCtrl(5), 32'h080);
    rd(aCnt(5), d);
    expRd("R9 unarmed", A_SN, 32'h1234);
    rd(aCnt(4), d);
    expRd("R9 leader read", A_SN, 32'h1234);
    wr(aCnt(6), 32'h4321); wr(aCtrl(7), 32'h280);
    rd(aCnt(7), d);
    expRd("R9 snap 10", A_SN, 32'h4321);

    // R10: simultaneous matches, irq timing, clear masking
    wr(A_ST, 32'hFFF);
    wr(aCtrl(0), 32'h81); wr(aMatch(0), 10); wr(aCnt(0), 8);
    wr(aCtrl(4), 32'h81); wr(aMatch(4), 20); wr(aCnt(4), 18);
    @(negedge clk); tickIn = 5'b1;
    @(negedge clk);
    @(negedge clk); tickIn = '0;
    chk("R10 irq one cycle late", 32'(irq), 0);
    @(negedge clk);
    chk("R10 irq asserted", 32'(irq), 1);
    expRd("R10 both set", A_ST, 32'h110);
    wr(A_ST, 32'h010);
    expRd("R10 partial clear", A_ST, 32'h100);
    chk("R10 irq stays", 32'(irq), 1);
    wr(A_ST, 32'hFFFF_F00F);
    expRd("R10 outside bits ignored", A_ST, 32'h100);
    wr(A_ST, 32'h100);
    @(negedge clk);
    chk("R10 irq dropped", 32'(irq), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule